// File: doc/BRIEF.md
# Time-Ordered Operand Capture Station

This block is one station of a time-ordered execution window. It holds a single instruction's source register numbers, the current values of those operands, a logical-order tag made of a column field and a row field, and the identifier of the execution path it belongs to. A shared result bus broadcasts register results. Each broadcast carries a register number, a value, the producer's tag and the producer's path.

The station takes a broadcast value only when a sequential run of the program would have delivered that value to it. The broadcast must come from the station's own path, must be older than the station itself, and must be newer than any value already taken for that operand. Every change of an operand raises a one-cycle execute request, so the instruction runs again with the new inputs. The final operand value therefore does not depend on the order in which results arrive.

A nullify broadcast withdraws the result the station last took for an operand and forces the instruction to run again. A column-shift strobe moves every tag in the window one column toward zero. The station shifts its own tag and its stored capture tags together, so later comparisons stay correct.

Top module: `snarf_station`

## Requirements
- R1: After reset the station is empty (`stn_valid`=0), all operands read 0 and `exec_req` is 0.
- R2: A load (`load_en`=1) stores the source numbers, the initial operand values, the column/row tag and the path. It clears each operand's record of captured results, and it raises `exec_req` in the following cycle. A load takes priority over a broadcast in the same cycle.
- R3: A broadcast is captured by each operand whose source number equals `bus_addr`, provided that the path matches, the bus tag is older than the station tag, and no result has been captured yet for that operand. The captured value appears on `opnd_out` and `exec_req` is 1 in the next cycle. Operand i occupies `opnd_out[i*DATA_W +: DATA_W]`, and its source is `load_src[i*ADDR_W +: ADDR_W]`.
- R4: A broadcast whose tag equals the station tag or is newer than it leaves the operands unchanged and raises no request.
- R5: A broadcast whose path differs from the station path is ignored.
- R6: A broadcast whose tag is older than, or equal to, the last captured tag for that operand is ignored. A late-arriving older result therefore never overwrites a newer one.
- R7: A broadcast newer than the last captured tag but still older than the station replaces the operand and raises `exec_req` again.
- R8: A nullify broadcast (`bus_nullify`=1) that matches an operand's source number, the path, and that operand's last captured tag raises `exec_req` and keeps the operand value. It clears the capture record, so the next older result is accepted. A nullify whose tag differs from the last captured tag is ignored.
- R9: `col_shift` decrements the station column and every stored capture column by one. Later comparisons use the shifted tags.
- R10: When a capture and `col_shift` occur in the same cycle, the decision uses the tags as they were before the shift.
- R11: Tag order compares the column first. The row decides only when the columns are equal, and a smaller value is older.
- R12: Operands that name the same source register capture the same broadcast together.
- R13: `exec_req` lasts one cycle per triggering event, and it stays 0 while the station is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load a new instruction |
| load_col | input | COL_W | Column field of the station tag |
| load_row | input | ROW_W | Row field of the station tag |
| load_path | input | PATH_W | Path identifier of the station |
| load_src | input | NUM_SRC*ADDR_W | Source register numbers |
| load_opnd | input | NUM_SRC*DATA_W | Initial operand values |
| col_shift | input | 1 | Window column shift strobe |
| bus_valid | input | 1 | Broadcast present |
| bus_nullify | input | 1 | Broadcast withdraws an earlier result |
| bus_addr | input | ADDR_W | Broadcast register number |
| bus_value | input | DATA_W | Broadcast value |
| bus_col | input | COL_W | Broadcast tag column |
| bus_row | input | ROW_W | Broadcast tag row |
| bus_path | input | PATH_W | Broadcast path identifier |
| stn_valid | output | 1 | Station holds an instruction |
| stn_col | output | COL_W | Current station column |
| stn_row | output | ROW_W | Station row |
| opnd_out | output | NUM_SRC*DATA_W | Current operand values |
| exec_req | output | 1 | Execute or re-execute request |

## Verification
The bench uses the default build: two operands, 5-bit register numbers, 32-bit values, a 4-bit column, a 3-bit row and a 2-bit path. Two source slots are enough to show one operand capturing while the other stays put, and to show two slots naming the same register capturing together. The 4-bit column leaves room for several shifts from a mid-window column. In those shifts a tag on the bus lands on either side of the station tag depending on whether the pre-shift or the post-shift frame is used. The 3-bit row allows equal-column cases in which the row alone decides the order.

// File: rtl/ts_pkg.sv
package ts_pkg;

    parameter int TS_COL_W = 4;
    parameter int TS_ROW_W = 3;

    typedef struct packed {
        logic [TS_COL_W-1:0] col;
        logic [TS_ROW_W-1:0] row;
    } ts_tag_t;

    // a is logically older than b
    function automatic logic ts_older(input ts_tag_t a, input ts_tag_t b);
        return (a.col < b.col) || ((a.col == b.col) && (a.row < b.row));
    endfunction

    // tag after one column shift of the window
    function automatic ts_tag_t ts_shifted(input ts_tag_t t);
        ts_tag_t r;
        r.col = t.col - 1'b1;
        r.row = t.row;
        return r;
    endfunction

endpackage

// File: rtl/ts_tag_reg.sv
module ts_tag_reg
    import ts_pkg::*;
#(
    parameter int PATH_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  ts_tag_t           load_tag,
    input  logic [PATH_W-1:0] load_path,
    input  logic              shift,
    output ts_tag_t           own_tag,
    output logic [PATH_W-1:0] own_path,
    output logic              own_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_tag   <= '0;
            own_path  <= '0;
            own_valid <= 1'b0;
        end else if (load_en) begin
            own_tag   <= load_tag;
            own_path  <= load_path;
            own_valid <= 1'b1;
        end else if (shift && own_valid) begin
            own_tag   <= ts_shifted(own_tag);
        end
    end

endmodule

// File: rtl/ts_operand_slot.sv
module ts_operand_slot
    import ts_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PATH_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  ts_tag_t           own_tag,
    input  logic [PATH_W-1:0] own_path,
    input  logic              own_valid,
    input  logic              bus_valid,
    input  logic              bus_nullify,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_val,
    input  ts_tag_t           bus_tag,
    input  logic [PATH_W-1:0] bus_path,
    output logic [DATA_W-1:0] value,
    output logic              update
);

    logic [ADDR_W-1:0] src_q;
    ts_tag_t           last_q;
    logic              last_vld_q;
    logic              hit, take, kill, newer_than_last;

    always_comb begin
        hit  = own_valid && !load_en && bus_valid &&
               (bus_addr == src_q) && (bus_path == own_path);
        newer_than_last = !last_vld_q || ts_older(last_q, bus_tag);
        take = hit && !bus_nullify && ts_older(bus_tag, own_tag) && newer_than_last;
        kill = hit && bus_nullify && last_vld_q && (bus_tag == last_q);
        update = take || kill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= '0;
            value      <= '0;
            last_q     <= '0;
            last_vld_q <= 1'b0;
        end else if (load_en) begin
            src_q      <= load_addr;
            value      <= load_val;
            last_q     <= '0;
            last_vld_q <= 1'b0;
        end else if (take) begin
            value      <= bus_val;
            last_q     <= shift ? ts_shifted(bus_tag) : bus_tag;
            last_vld_q <= 1'b1;
        end else if (kill) begin
            last_vld_q <= 1'b0;
        end else if (shift && last_vld_q) begin
            last_q     <= ts_shifted(last_q);
        end
    end

endmodule

// File: rtl/ts_exec_pulse.sv
module ts_exec_pulse #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [NUM_SRC-1:0] slot_update,
    output logic               exec_req
);

    always_ff @(posedge clk) begin
        if (rst) exec_req <= 1'b0;
        else     exec_req <= load_en || (|slot_update);
    end

endmodule

// File: rtl/snarf_station.sv
module snarf_station
    import ts_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int PATH_W  = 2,
    parameter int COL_W   = TS_COL_W,
    parameter int ROW_W   = TS_ROW_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_en,
    input  logic [COL_W-1:0]          load_col,
    input  logic [ROW_W-1:0]          load_row,
    input  logic [PATH_W-1:0]         load_path,
    input  logic [NUM_SRC*ADDR_W-1:0] load_src,
    input  logic [NUM_SRC*DATA_W-1:0] load_opnd,
    input  logic                      col_shift,
    input  logic                      bus_valid,
    input  logic                      bus_nullify,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_value,
    input  logic [COL_W-1:0]          bus_col,
    input  logic [ROW_W-1:0]          bus_row,
    input  logic [PATH_W-1:0]         bus_path,
    output logic                      stn_valid,
    output logic [COL_W-1:0]          stn_col,
    output logic [ROW_W-1:0]          stn_row,
    output logic [NUM_SRC*DATA_W-1:0] opnd_out,
    output logic                      exec_req
);

    ts_tag_t           load_tag, bus_tag, own_tag;
    logic [PATH_W-1:0] own_path;
    logic              own_valid;
    logic [NUM_SRC-1:0] slot_update;

    assign load_tag  = '{col: load_col, row: load_row};
    assign bus_tag   = '{col: bus_col,  row: bus_row};
    assign stn_valid = own_valid;
    assign stn_col   = own_tag.col;
    assign stn_row   = own_tag.row;

    ts_tag_reg #(.PATH_W(PATH_W)) u_tag (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_tag  (load_tag),
        .load_path (load_path),
        .shift     (col_shift),
        .own_tag   (own_tag),
        .own_path  (own_path),
        .own_valid (own_valid)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        ts_operand_slot #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .PATH_W (PATH_W)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .load_en     (load_en),
            .load_addr   (load_src[i*ADDR_W +: ADDR_W]),
            .load_val    (load_opnd[i*DATA_W +: DATA_W]),
            .shift       (col_shift),
            .own_tag     (own_tag),
            .own_path    (own_path),
            .own_valid   (own_valid),
            .bus_valid   (bus_valid),
            .bus_nullify (bus_nullify),
            .bus_addr    (bus_addr),
            .bus_val     (bus_value),
            .bus_tag     (bus_tag),
            .bus_path    (bus_path),
            .value       (opnd_out[i*DATA_W +: DATA_W]),
            .update      (slot_update[i])
        );
    end

    ts_exec_pulse #(.NUM_SRC(NUM_SRC)) u_pulse (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .slot_update (slot_update),
        .exec_req    (exec_req)
    );

endmodule

// File: rtl/ts_station_chk.sv
module ts_station_chk
    import ts_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int DATA_W  = 32,
    parameter int PATH_W  = 2,
    parameter int COL_W   = TS_COL_W,
    parameter int ROW_W   = TS_ROW_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      load_en,
    input logic                      col_shift,
    input logic                      bus_valid,
    input logic [COL_W-1:0]          bus_col,
    input logic [ROW_W-1:0]          bus_row,
    input logic [PATH_W-1:0]         bus_path,
    input logic [PATH_W-1:0]         own_path,
    input logic                      bus_nullify,
    input logic                      stn_valid,
    input logic [COL_W-1:0]          stn_col,
    input logic [ROW_W-1:0]          stn_row,
    input logic [NUM_SRC*DATA_W-1:0] opnd_out,
    input logic                      exec_req
);

    logic bus_not_older;
    assign bus_not_older = (bus_col > stn_col) ||
                           ((bus_col == stn_col) && (bus_row >= stn_row));

    p_load_req_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> exec_req);

    p_late_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (stn_valid && !load_en && bus_valid && !bus_nullify && bus_not_older)
        |=> ($stable(opnd_out) && !exec_req));

    p_path_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (stn_valid && !load_en && bus_valid && bus_path != own_path)
        |=> ($stable(opnd_out) && !exec_req));

    p_shift_col_r9: assert property (@(posedge clk) disable iff (rst)
        (stn_valid && !load_en && col_shift)
        |=> (stn_col == $past(stn_col) - 1'b1) && $stable(stn_row));

    p_quiet_idle_r13: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !bus_valid) |=> (!exec_req && $stable(opnd_out)));

    p_empty_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (!stn_valid && !load_en) |=> !exec_req);

endmodule

bind snarf_station ts_station_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .PATH_W  (PATH_W),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W)
) u_chk (.*);

// File: tb/tb_snarf_station.sv
module tb_snarf_station;

    localparam int NS = 2, DW = 32, AW = 5, PW = 2, CW = 4, RW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic load_en = 0, col_shift = 0, bus_valid = 0, bus_nullify = 0;
    logic [CW-1:0] load_col = 0, bus_col = 0;
    logic [RW-1:0] load_row = 0, bus_row = 0;
    logic [PW-1:0] load_path = 0, bus_path = 0;
    logic [NS*AW-1:0] load_src = 0;
    logic [NS*DW-1:0] load_opnd = 0, opnd_out;
    logic [AW-1:0] bus_addr = 0;
    logic [DW-1:0] bus_value = 0;
    logic stn_valid, exec_req;
    logic [CW-1:0] stn_col;
    logic [RW-1:0] stn_row;

    typedef struct {
        string     req;
        logic [DW-1:0] e0, e1;
        logic      ex, vld;
        logic [CW-1:0] col;
    } exp_t;

    exp_t sb[$];
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    snarf_station dut (.*);

    // monitor: compare expectations as results appear
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (opnd_out[DW-1:0] !== e.e0 || opnd_out[2*DW-1:DW] !== e.e1 ||
                exec_req !== e.ex || stn_valid !== e.vld || stn_col !== e.col) begin
                errors++;
                $display("FAIL %s: got op0=%h op1=%h ex=%b vld=%b col=%0d exp op0=%h op1=%h ex=%b vld=%b col=%0d",
                         e.req, opnd_out[DW-1:0], opnd_out[2*DW-1:DW], exec_req, stn_valid,
                         stn_col, e.e0, e.e1, e.ex, e.vld, e.col);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] v,
                       input int c, input int r, input int p, input logic nul);
        bus_valid = 1; bus_nullify = nul; bus_addr = a; bus_value = v;
        bus_col = CW'(c); bus_row = RW'(r); bus_path = PW'(p);
    endtask

    // one cycle: inputs already set at negedge; push expectation; clear inputs
    task automatic cyc(input string req, input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                       input logic ex, input logic vld, input int col);
        exp_t e;
        @(posedge clk);
        #1;
        e.req = req; e.e0 = e0; e.e1 = e1; e.ex = ex; e.vld = vld; e.col = CW'(col);
        sb.push_back(e);
        @(negedge clk);
        load_en = 0; col_shift = 0; bus_valid = 0; bus_nullify = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        cyc("R1 reset", 0, 0, 0, 0, 0);
        bus(5'd3, 32'hDEAD, 0, 0, 1, 0);
        cyc("R13 empty ignores bus", 0, 0, 0, 0, 0);
        // load: src0=3, src1=7, tag (5,2), path 1
        load_en = 1; load_col = 5; load_row = 2; load_path = 1;
        load_src = {5'd7, 5'd3}; load_opnd = {32'h200, 32'h100};
        bus(5'd3, 32'hBAD, 0, 0, 1, 0);
        cyc("R2 load", 32'h100, 32'h200, 1, 1, 5);
        cyc("R13 single pulse", 32'h100, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hA1, 2, 0, 1, 0);
        cyc("R3 first capture", 32'hA1, 32'h200, 1, 1, 5);
        cyc("R13 pulse ends", 32'hA1, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hB0, 5, 2, 1, 0);
        cyc("R4 equal own tag", 32'hA1, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hB1, 6, 0, 1, 0);
        cyc("R4 newer than own", 32'hA1, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hB2, 3, 1, 2, 0);
        cyc("R5 other path", 32'hA1, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hA2, 3, 1, 1, 0);
        cyc("R7 newer capture", 32'hA2, 32'h200, 1, 1, 5);
        bus(5'd3, 32'hA3, 2, 5, 1, 0);
        cyc("R6 older late arrival", 32'hA2, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hA4, 3, 1, 1, 0);
        cyc("R6 equal last", 32'hA2, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hA5, 3, 0, 1, 0);
        cyc("R11 smaller row same col", 32'hA2, 32'h200, 0, 1, 5);
        bus(5'd3, 32'hA6, 3, 2, 1, 0);
        cyc("R11 larger row same col", 32'hA6, 32'h200, 1, 1, 5);
        bus(5'd3, 32'hA7, 4, 0, 1, 0);
        cyc("R11 column dominates row", 32'hA7, 32'h200, 1, 1, 5);
        bus(5'd7, 32'hC1, 1, 0, 1, 0);
        cyc("R3 second operand", 32'hA7, 32'hC1, 1, 1, 5);
        bus(5'd7, 32'h0, 3, 3, 1, 1);
        cyc("R8 nullify wrong tag", 32'hA7, 32'hC1, 0, 1, 5);
        bus(5'd3, 32'h0, 4, 0, 1, 1);
        cyc("R8 nullify re-exec", 32'hA7, 32'hC1, 1, 1, 5);
        bus(5'd3, 32'hA8, 2, 0, 1, 0);
        cyc("R8 record cleared", 32'hA8, 32'hC1, 1, 1, 5);
        col_shift = 1;
        cyc("R9 shift", 32'hA8, 32'hC1, 0, 1, 4);
        bus(5'd3, 32'hD0, 4, 3, 1, 0);
        cyc("R9 own tag shifted", 32'hA8, 32'hC1, 0, 1, 4);
        bus(5'd3, 32'hD1, 1, 5, 1, 0);
        cyc("R9 stored tag shifted", 32'hD1, 32'hC1, 1, 1, 4);
        col_shift = 1;
        bus(5'd3, 32'hE1, 4, 1, 1, 0);
        cyc("R10 pre-shift compare", 32'hE1, 32'hC1, 1, 1, 3);
        // both sources name register 9
        load_en = 1; load_col = 6; load_row = 0; load_path = 0;
        load_src = {5'd9, 5'd9}; load_opnd = {32'h2, 32'h1};
        cyc("R2 reload", 32'h1, 32'h2, 1, 1, 6);
        bus(5'd9, 32'h77, 2, 2, 0, 0);
        cyc("R12 shared source", 32'h77, 32'h77, 1, 1, 6);
        cyc("R13 final idle", 32'h77, 32'h77, 0, 1, 6);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule